// File: doc/BRIEF.md
# PHY Reset and Static Link Configuration Sequencer

This block drives an Ethernet PHY from an unknown state to a fixed link setting. It sits above an MDIO management master and uses a simple request/done handshake to give that master one register command at a time. When `start` is pulsed, the block first asks the PHY to soft-reset itself. It then reads the PHY control register repeatedly until the self-clearing reset flag drops. Finally it writes a static control word that selects either 10 Mb/s half duplex or 100 Mb/s full duplex.

If the reset flag is still set once half a second of system clocks has passed since the reset command completed, the block gives up. It raises a sticky failure flag and writes no configuration. When the sequence succeeds, it raises a completion flag and drives the MAC duplex output to match the chosen mode. The timeout length is a parameter derived from the clock frequency. A bench can shorten it.

Top module: `phy_init_seq`

## Requirements
- R1: After reset, or while the completion or failure flag is set, a `start` pulse makes the first command a write (`mdio_write`=1) of 16'h8000 to control register address 0. `mdio_phy_addr` always equals the `PHY_ADDR` parameter, and every command targets register address 0.
- R2: When the reset write's done arrives, the block issues reads (`mdio_write`=0) of register 0. After each read whose data has bit 15 = 1, `mdio_req` is low for at least one cycle before the next read starts. Reads continue until a read returns bit 15 = 0.
- R3: With `mode_sel`=0 latched at start (10 Mb/s half duplex), the configuration command is a write of 16'h0000 to register 0.
- R4: With `mode_sel`=1 latched at start (100 Mb/s full duplex), the configuration command is a write of 16'h2100 to register 0 (bit 13 speed, bit 8 duplex).
- R5: `seq_done` rises in the cycle after the configuration write's done is accepted, and `mac_full_duplex` then equals the latched mode. `seq_done` stays high until the next accepted `start`, which clears it in the following cycle.
- R6: A read that returns bit 15 = 1 once `TIMEOUT_CYC` cycles have passed since the reset write completed sends the block to failure. `seq_fail` then rises, no configuration write is issued, and `seq_fail` holds until the next accepted `start`.
- R7: `mac_full_duplex` resets to 0 (half duplex) and keeps its previous value when a sequence fails.
- R8: A `start` pulse while a sequence is in progress is ignored: no second reset write occurs and the latched mode does not change.
- R9: `mdio_req` stays high until `mdio_done` is seen, and `mdio_write`, `mdio_reg_addr` and `mdio_wdata` stay stable throughout.
- R10: During and right after reset, `mdio_req`, `seq_done` and `seq_fail` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Pulse to begin a reset/configure sequence |
| mode_sel | input | 1 | 0 = 10 Mb/s half duplex, 1 = 100 Mb/s full duplex; sampled with start |
| mdio_req | output | 1 | Command request to MDIO master, held until done |
| mdio_write | output | 1 | 1 = write command, 0 = read command |
| mdio_phy_addr | output | 5 | PHY address of the command |
| mdio_reg_addr | output | 5 | PHY register address of the command |
| mdio_wdata | output | 16 | Write data of the command |
| mdio_done | input | 1 | One-cycle completion pulse from MDIO master |
| mdio_rdata | input | 16 | Read data, valid with mdio_done on a read |
| mac_full_duplex | output | 1 | Duplex setting for the MAC, 1 = full |
| seq_done | output | 1 | Sequence completed successfully |
| seq_fail | output | 1 | Reset flag did not clear before the timeout |

## Verification
A wrong sequencer state shows up at the command port within one handshake: the wrong write word, a read issued where a write belongs, or a request that never drops. The MDIO model checks each of these as the command completes. A broken timeout counter shows up as a failure flag that rises too early or too late relative to the reset write's completion, so the bench measures that interval in cycles. A corrupted duplex register or a mode latch that follows `start` mid-sequence is exposed at the end of each sequence by comparing `mac_full_duplex` and the configuration word with the mode given at the accepted start.

// File: rtl/phy_init_pkg.sv
package phy_init_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_RST,
        S_POLL,
        S_GAP,
        S_CFG,
        S_DONE,
        S_FAIL
    } seq_state_t;

    typedef enum logic {
        MODE_10HD  = 1'b0,
        MODE_100FD = 1'b1
    } link_mode_t;

    typedef struct packed {
        logic        write;
        logic [4:0]  reg_addr;
        logic [15:0] data;
    } mgmt_cmd_t;

    localparam logic [4:0] CTRL_REG   = 5'd0;
    localparam int         RST_BIT    = 15;
    localparam int         SPEED_BIT  = 13;
    localparam int         DUPLEX_BIT = 8;

    function automatic logic [15:0] reset_word();
        logic [15:0] w;
        w = '0;
        w[RST_BIT] = 1'b1;
        return w;
    endfunction

    function automatic logic [15:0] cfg_word(link_mode_t m);
        logic [15:0] w;
        w = '0;
        if (m == MODE_100FD) begin
            w[SPEED_BIT]  = 1'b1;
            w[DUPLEX_BIT] = 1'b1;
        end
        return w;
    endfunction

endpackage

// File: rtl/phy_init_timer.sv
module phy_init_timer #(
    parameter int LIMIT = 25_000_000
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    output logic expired
);
    localparam int         W   = $clog2(LIMIT + 1);
    localparam logic [W-1:0] LIM = W'(LIMIT);

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (cnt != LIM) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign expired = (cnt == LIM);
endmodule

// File: rtl/phy_init_fsm.sv
module phy_init_fsm
    import phy_init_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       mode_sel,
    input  logic       mdio_done,
    input  logic       poll_busy,
    input  logic       expired,
    output logic       req,
    output mgmt_cmd_t  cmd,
    output logic       timer_clr,
    output logic       cfg_commit,
    output link_mode_t commit_mode,
    output logic       seq_done,
    output logic       seq_fail
);
    seq_state_t state;
    link_mode_t mode_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= S_IDLE;
            mode_q <= MODE_10HD;
        end else begin
            case (state)
                S_IDLE, S_DONE, S_FAIL: begin
                    if (start) begin
                        state  <= S_RST;
                        mode_q <= link_mode_t'(mode_sel);
                    end
                end
                S_RST: begin
                    if (mdio_done) state <= S_POLL;
                end
                S_POLL: begin
                    if (mdio_done) begin
                        if (!poll_busy)   state <= S_CFG;
                        else if (expired) state <= S_FAIL;
                        else              state <= S_GAP;
                    end
                end
                S_GAP: begin
                    state <= expired ? S_FAIL : S_POLL;
                end
                S_CFG: begin
                    if (mdio_done) state <= S_DONE;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    always_comb begin
        cmd = '{write: 1'b0, reg_addr: CTRL_REG, data: 16'h0000};
        case (state)
            S_RST: cmd = '{write: 1'b1, reg_addr: CTRL_REG, data: reset_word()};
            S_CFG: cmd = '{write: 1'b1, reg_addr: CTRL_REG, data: cfg_word(mode_q)};
            default: ;
        endcase
    end

    assign req         = (state == S_RST) || (state == S_POLL) || (state == S_CFG);
    assign timer_clr   = (state == S_RST);
    assign cfg_commit  = (state == S_CFG) && mdio_done;
    assign commit_mode = mode_q;
    assign seq_done    = (state == S_DONE);
    assign seq_fail    = (state == S_FAIL);
endmodule

// File: rtl/phy_init_duplex.sv
module phy_init_duplex
    import phy_init_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       commit,
    input  link_mode_t mode,
    output logic       full_duplex
);
    always_ff @(posedge clk) begin
        if (rst) begin
            full_duplex <= 1'b0;
        end else if (commit) begin
            full_duplex <= (mode == MODE_100FD);
        end
    end
endmodule

// File: rtl/phy_init_seq.sv
module phy_init_seq
    import phy_init_pkg::*;
#(
    parameter int         CLK_HZ      = 50_000_000,
    parameter int         TIMEOUT_CYC = CLK_HZ / 2,
    parameter logic [4:0] PHY_ADDR    = 5'd1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic        mode_sel,
    output logic        mdio_req,
    output logic        mdio_write,
    output logic [4:0]  mdio_phy_addr,
    output logic [4:0]  mdio_reg_addr,
    output logic [15:0] mdio_wdata,
    input  logic        mdio_done,
    input  logic [15:0] mdio_rdata,
    output logic        mac_full_duplex,
    output logic        seq_done,
    output logic        seq_fail
);
    mgmt_cmd_t  cmd;
    logic       timer_clr;
    logic       expired;
    logic       cfg_commit;
    link_mode_t commit_mode;
    logic       poll_busy;
    logic       unused_rdata_bits;

    assign poll_busy         = mdio_rdata[RST_BIT];
    assign unused_rdata_bits = ^mdio_rdata[RST_BIT-1:0];

    phy_init_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .mode_sel    (mode_sel),
        .mdio_done   (mdio_done),
        .poll_busy   (poll_busy),
        .expired     (expired),
        .req         (mdio_req),
        .cmd         (cmd),
        .timer_clr   (timer_clr),
        .cfg_commit  (cfg_commit),
        .commit_mode (commit_mode),
        .seq_done    (seq_done),
        .seq_fail    (seq_fail)
    );

    phy_init_timer #(.LIMIT(TIMEOUT_CYC)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .clr     (timer_clr),
        .expired (expired)
    );

    phy_init_duplex u_duplex (
        .clk         (clk),
        .rst         (rst),
        .commit      (cfg_commit),
        .mode        (commit_mode),
        .full_duplex (mac_full_duplex)
    );

    assign mdio_write    = cmd.write;
    assign mdio_reg_addr = cmd.reg_addr;
    assign mdio_wdata    = cmd.data;
    assign mdio_phy_addr = PHY_ADDR;
endmodule

// File: rtl/phy_init_seq_chk.sv
module phy_init_seq_chk (
    input logic        clk,
    input logic        rst,
    input logic        start,
    input logic        mdio_req,
    input logic        mdio_write,
    input logic [4:0]  mdio_reg_addr,
    input logic [15:0] mdio_wdata,
    input logic        mdio_done,
    input logic        rd_busy,
    input logic        mac_full_duplex,
    input logic        seq_done,
    input logic        seq_fail
);
    // R9: request held until done, with stable fields
    a_r9_req_held: assert property (@(posedge clk) disable iff (rst)
        mdio_req && !mdio_done |=> mdio_req);
    a_r9_cmd_stable: assert property (@(posedge clk) disable iff (rst)
        mdio_req && !mdio_done |=> $stable(mdio_write) && $stable(mdio_reg_addr) && $stable(mdio_wdata));
    // R1: every command targets the control register
    a_r1_ctrl_reg: assert property (@(posedge clk) disable iff (rst)
        mdio_req |-> mdio_reg_addr == 5'd0);
    // R2: idle gap after a busy poll read
    a_r2_read_gap: assert property (@(posedge clk) disable iff (rst)
        mdio_req && mdio_done && !mdio_write && rd_busy |=> !mdio_req);
    // R3 / R4: only the legal write words appear
    a_r3_r4_write_word: assert property (@(posedge clk) disable iff (rst)
        mdio_req && mdio_write |-> (mdio_wdata == 16'h8000 || mdio_wdata == 16'h0000 || mdio_wdata == 16'h2100));
    // R5: done and fail never together
    a_r5_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(seq_done && seq_fail));
    a_r5_done_hold: assert property (@(posedge clk) disable iff (rst)
        seq_done && !start |=> seq_done);
    // R6: failure is sticky
    a_r6_fail_hold: assert property (@(posedge clk) disable iff (rst)
        seq_fail && !start |=> seq_fail);
    // R7: duplex unchanged when failure is entered
    a_r7_dup_kept: assert property (@(posedge clk) disable iff (rst)
        $rose(seq_fail) |-> $stable(mac_full_duplex));
    // R10: no request while flags are up
    a_r10_quiet_flags: assert property (@(posedge clk) disable iff (rst)
        (seq_done || seq_fail) |-> !mdio_req);
endmodule

bind phy_init_seq phy_init_seq_chk u_chk (
    .clk             (clk),
    .rst             (rst),
    .start           (start),
    .mdio_req        (mdio_req),
    .mdio_write      (mdio_write),
    .mdio_reg_addr   (mdio_reg_addr),
    .mdio_wdata      (mdio_wdata),
    .mdio_done       (mdio_done),
    .rd_busy         (mdio_rdata[15]),
    .mac_full_duplex (mac_full_duplex),
    .seq_done        (seq_done),
    .seq_fail        (seq_fail)
);

// File: tb/phy_init_seq_tb.sv
module phy_init_seq_tb;
    localparam int         TO  = 150;
    localparam logic [4:0] PHY = 5'd7;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        mode_sel = 1'b0;
    logic        mdio_done = 1'b0;
    logic [15:0] mdio_rdata = 16'h0000;
    logic        mdio_req, mdio_write, mac_full_duplex, seq_done, seq_fail;
    logic [4:0]  mdio_phy_addr, mdio_reg_addr;
    logic [15:0] mdio_wdata;

    phy_init_seq #(.CLK_HZ(1000), .TIMEOUT_CYC(TO), .PHY_ADDR(PHY)) u_dut (
        .clk(clk), .rst(rst), .start(start), .mode_sel(mode_sel),
        .mdio_req(mdio_req), .mdio_write(mdio_write), .mdio_phy_addr(mdio_phy_addr),
        .mdio_reg_addr(mdio_reg_addr), .mdio_wdata(mdio_wdata),
        .mdio_done(mdio_done), .mdio_rdata(mdio_rdata),
        .mac_full_duplex(mac_full_duplex), .seq_done(seq_done), .seq_fail(seq_fail)
    );

    always #10 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // responder bookkeeping
    int          rst_writes, cfg_writes, reads, bad_reg, stable_bad, gap_bad;
    int          busy_left, rst_done_cyc, lat_max;
    bit          never_clear, last_busy;
    logic [15:0] cfg_data;
    logic        c_w;
    logic [4:0]  c_ra;
    logic [15:0] c_wd;
    int          c_lat;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_cfg(input bit m);
        return m ? 16'h2100 : 16'h0000;
    endfunction

    // MDIO master model
    initial begin
        forever begin
            @(negedge clk);
            mdio_done = 1'b0;
            if (mdio_req && !rst) begin
                if (last_busy) gap_bad++;
                last_busy = 1'b0;
                c_w  = mdio_write;
                c_ra = mdio_reg_addr;
                c_wd = mdio_wdata;
                c_lat = $urandom_range(0, lat_max);
                repeat (c_lat) begin
                    @(negedge clk);
                    if (!mdio_req || mdio_write !== c_w || mdio_reg_addr !== c_ra || mdio_wdata !== c_wd)
                        stable_bad++;
                end
                if (c_ra != 5'd0) bad_reg++;
                if (c_w) begin
                    if (c_wd == 16'h8000) begin
                        rst_writes++;
                        rst_done_cyc = cyc;
                    end else begin
                        cfg_writes++;
                        cfg_data = c_wd;
                    end
                end else begin
                    reads++;
                    if (never_clear || busy_left > 0) begin
                        mdio_rdata = 16'h8000 | 16'($urandom_range(0, 16'h7fff));
                        if (busy_left > 0) busy_left--;
                        last_busy = 1'b1;
                    end else begin
                        mdio_rdata = 16'($urandom_range(0, 16'h7fff));
                    end
                end
                mdio_done = 1'b1;
            end else begin
                last_busy = 1'b0;
            end
        end
    end

    task automatic run_seq(input bit m, input int k, input bit nev, input bit poke);
        bit prev_dup;
        int n;
        int fail_cyc;
        int elapsed;
        prev_dup = mac_full_duplex;
        rst_writes = 0; cfg_writes = 0; reads = 0; bad_reg = 0;
        stable_bad = 0; gap_bad = 0; busy_left = k; never_clear = nev;
        cfg_data = 16'hdead;
        @(negedge clk);
        mode_sel = m;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        mode_sel = ~m;
        check(seq_done == 1'b0 && seq_fail == 1'b0, "R5", "flags cleared by start",
              {seq_done, seq_fail}, 0);
        if (poke) begin
            repeat (3) @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        n = 0;
        while (!(seq_done || seq_fail) && n < TO * 4 + 500) begin
            @(negedge clk);
            n++;
        end
        fail_cyc = cyc;
        check(seq_done || seq_fail, "R6", "sequence ended", 0, 1);
        check(bad_reg == 0, "R1", "register address 0", bad_reg, 0);
        check(rst_writes == 1, poke ? "R8" : "R1", "reset writes", rst_writes, 1);
        check(stable_bad == 0, "R9", "command held until done", stable_bad, 0);
        check(gap_bad == 0, "R2", "gap between reads", gap_bad, 0);
        if (!nev) begin
            check(seq_done == 1'b1 && seq_fail == 1'b0, "R5", "done flag", {seq_done, seq_fail}, 2);
            check(reads == k + 1, "R2", "poll read count", reads, k + 1);
            check(cfg_writes == 1, m ? "R4" : "R3", "config write count", cfg_writes, 1);
            check(cfg_data == exp_cfg(m), m ? "R4" : "R3", "config word", cfg_data, exp_cfg(m));
            check(mac_full_duplex == m, poke ? "R8" : "R5", "mac duplex", mac_full_duplex, m);
        end else begin
            elapsed = fail_cyc - rst_done_cyc;
            check(seq_fail == 1'b1 && seq_done == 1'b0, "R6", "fail flag", {seq_done, seq_fail}, 1);
            check(cfg_writes == 0, "R6", "no config write on fail", cfg_writes, 0);
            check(mac_full_duplex == prev_dup, "R7", "duplex kept on fail", mac_full_duplex, prev_dup);
            check(elapsed >= TO && elapsed <= TO + lat_max + 8, "R6", "fail timing",
                  elapsed, TO);
        end
        repeat (5) @(negedge clk);
        if (!nev) check(seq_done == 1'b1, "R5", "done held", seq_done, 1);
        else      check(seq_fail == 1'b1, "R6", "fail held", seq_fail, 1);
        check(mdio_req == 1'b0, "R10", "no request after end", mdio_req, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        bit rm;
        bit rn;
        void'($urandom(32'd2024));
        lat_max = 0;
        repeat (4) @(negedge clk);
        check(mdio_req == 1'b0 && seq_done == 1'b0 && seq_fail == 1'b0, "R10",
              "outputs in reset", {mdio_req, seq_done, seq_fail}, 0);
        rst = 1'b0;
        @(negedge clk);
        check(mdio_req == 1'b0 && seq_done == 1'b0 && seq_fail == 1'b0, "R10",
              "outputs after reset", {mdio_req, seq_done, seq_fail}, 0);
        check(mac_full_duplex == 1'b0, "R7", "duplex reset value", mac_full_duplex, 0);
        check(mdio_phy_addr == PHY, "R1", "phy address", mdio_phy_addr, PHY);

        // directed corner cases
        run_seq(1'b1, 0, 1'b0, 1'b0);
        run_seq(1'b0, 0, 1'b0, 1'b0);
        lat_max = 6;
        run_seq(1'b1, 3, 1'b0, 1'b0);
        run_seq(1'b0, 0, 1'b1, 1'b0);
        run_seq(1'b1, 2, 1'b0, 1'b0);
        run_seq(1'b0, 0, 1'b1, 1'b0);
        run_seq(1'b0, 2, 1'b0, 1'b1);
        run_seq(1'b1, 1, 1'b0, 1'b1);

        // constrained random
        for (int i = 0; i < 12; i++) begin
            lat_max = $urandom_range(0, 6);
            rm = 1'($urandom_range(0, 1));
            rn = ($urandom_range(0, 4) == 0);
            run_seq(rm, $urandom_range(0, 5), rn, ($urandom_range(0, 3) == 0));
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule